// File: doc/BRIEF.md
# In-Order Completion Queue

This block tracks instructions from dispatch to retirement so that a core whose execution units finish out of order still updates its architectural registers in program order. It is a circular buffer of `DEPTH` slots, six by default. Each dispatch lane offers one instruction per cycle. An accepted instruction that needs tracking takes the next free slot, and the slot index comes back as its tag. Execution units later report completion against that tag and return the result value.

Each cycle, retirement inspects the oldest slots. It releases as many consecutive finished entries as the retire width allows, and presents each one as a commit strobe with its destination class, register index and value. There are two kinds of branch. A branch that updates neither the link nor the count register is acknowledged without taking a slot. A branch that updates one of them takes a slot that is marked finished at once, carries its value in with it, and is never offered for issue.

A flush request names a slot. It discards that slot and everything younger, and the next allocation reuses the named slot. This is how the core recovers from a mispredicted branch or an exception.

Top module: `cmpl_queue`

## Requirements
- R1: Slots are handed out in ring order, wrapping from `DEPTH-1` to 0. Within one cycle, lane 0 is older than lane 1. `disp_tag_o` of an accepted slot-taking lane gives the slot it received.
- R2: A slot-taking lane is refused when no slot is free at the start of the cycle. A retirement in the same cycle does not free a slot early. Once a lane is refused, every higher lane is refused in that cycle.
- R3: `count_o` equals the number of occupied slots, and it stays correct when allocation and retirement happen in the same cycle. `full_o` is high when `count_o` equals `DEPTH`. `empty_o` is high when `count_o` is 0.
- R4: Kind code 1 (a branch that writes no link or count register) is acknowledged without taking a slot or consuming a tag, and it never asserts `issue_o`.
- R5: Kind code 2 (a branch that writes the link or count register) takes a slot and never asserts `issue_o`. It counts as finished from dispatch, with `disp_value_i` as its result.
- R6: Kind code 0 (an ordinary instruction) asserts `issue_o` on its lane when accepted. It stays unfinished until a finish report names its tag.
- R7: Commits happen only from the oldest slot onward, and up to `RET_N` consecutive finished entries commit per cycle. An unfinished older entry holds back every younger one. A finish report raises the commit strobe in the following cycle.
- R8: Each commit lane presents the entry's destination class (0 general, 1 floating-point, 2 link, 3 count), its register index and its result value. Lane 0 always carries the oldest committing entry.
- R9: In a cycle where `flush_i` is high, no commit happens and no dispatch is accepted. If `flush_tag_i` names an occupied slot, that slot and all younger ones are freed. The next allocation then receives that slot, and the count drops to the number of older entries.
- R10: A finish report for a slot that holds no entry is ignored. A flush naming a slot that holds no entry changes nothing.
- R11: After reset the queue is empty, the count is 0, and no commit strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | DISP_N | Dispatch offer per lane |
| disp_kind_i | input | DISP_N x 2 | 0 ordinary, 1 branch without register write, 2 branch writing link/count |
| disp_dst_i | input | DISP_N x 2 | Destination class: 0 general, 1 floating-point, 2 link, 3 count |
| disp_idx_i | input | DISP_N x 5 | Destination register index |
| disp_value_i | input | DISP_N x DATA_W | Result carried by a kind-2 branch |
| disp_ack_o | output | DISP_N | Lane accepted this cycle |
| disp_tag_o | output | DISP_N x PTR_W | Slot given to the lane |
| issue_o | output | DISP_N | Lane is to be sent to an execution unit |
| fin_valid_i | input | FIN_N | Finish report per port |
| fin_tag_i | input | FIN_N x PTR_W | Slot that finished |
| fin_data_i | input | FIN_N x DATA_W | Result value |
| flush_i | input | 1 | Discard the named slot and all younger ones |
| flush_tag_i | input | PTR_W | Oldest slot to discard |
| commit_valid_o | output | RET_N | Commit strobe per retire lane |
| commit_dst_o | output | RET_N x 2 | Destination class of the committing entry |
| commit_idx_o | output | RET_N x 5 | Destination register index |
| commit_data_o | output | RET_N x DATA_W | Value to write |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |
| count_o | output | CNT_W | Occupied slots |

## Verification
Some rules hold on every cycle, and the checker watches those. The occupancy never exceeds the depth and always moves by exactly the accepted allocations minus the commits. A full queue never accepts a slot-taking lane. Commit strobes form a contiguous run from lane 0. Branch kinds never raise an issue strobe. A flush cycle is silent on both the dispatch and the commit side. Other behaviour can only be shown by the bench scenarios compared against its reference queue model. That covers which slot a tag names, that a finish report lets an entry retire exactly one cycle later, that an unfinished head holds back finished younger entries, where the ring tail lands after a flush, and that reports or flushes aimed at empty slots leave no trace.

// File: rtl/cmpl_queue_pkg.sv
package cmpl_queue_pkg;

  localparam int IDX_W = 5;

  typedef enum logic [1:0] {
    KIND_OP       = 2'd0,
    KIND_BR_NOREG = 2'd1,
    KIND_BR_REG   = 2'd2,
    KIND_RSVD     = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    DST_GPR = 2'd0,
    DST_FPR = 2'd1,
    DST_LR  = 2'd2,
    DST_CTR = 2'd3
  } dst_e;

  typedef struct packed {
    logic             valid;
    logic             done;
    dst_e             dst;
    logic [IDX_W-1:0] idx;
  } meta_t;

  function automatic int ring_add(int p, int n, int depth);
    return (p + n) % depth;
  endfunction

  // distance walking forward from 'from' to 'to'
  function automatic int ring_dist(int from, int to, int depth);
    return (to + depth - from) % depth;
  endfunction

endpackage

// File: rtl/cq_alloc.sv
module cq_alloc
  import cmpl_queue_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DISP_N = 2,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 3
) (
  input  logic [DISP_N-1:0]            valid_i,
  input  logic [DISP_N-1:0][1:0]       kind_i,
  input  logic                         flush_i,
  input  logic [CNT_W-1:0]             count_i,
  input  logic [PTR_W-1:0]             tail_i,
  output logic [DISP_N-1:0]            ack_o,
  output logic [DISP_N-1:0]            take_o,
  output logic [DISP_N-1:0]            issue_o,
  output logic [DISP_N-1:0][PTR_W-1:0] slot_o,
  output logic [CNT_W-1:0]             n_take_o
);

  always_comb begin
    int   used;
    int   free;
    logic blocked;
    free    = DEPTH - int'(count_i);
    used    = 0;
    blocked = flush_i;
    for (int l = 0; l < DISP_N; l++) begin
      ack_o[l]   = 1'b0;
      take_o[l]  = 1'b0;
      issue_o[l] = 1'b0;
      slot_o[l]  = PTR_W'(ring_add(int'(tail_i), used, DEPTH));
      if (valid_i[l] && !blocked) begin
        if (kind_e'(kind_i[l]) == KIND_BR_NOREG) begin
          ack_o[l] = 1'b1;
        end else if (used < free) begin
          ack_o[l]   = 1'b1;
          take_o[l]  = 1'b1;
          issue_o[l] = (kind_e'(kind_i[l]) != KIND_BR_REG);
          used       = used + 1;
        end else begin
          blocked = 1'b1;  // keep program order across lanes
        end
      end
    end
    n_take_o = CNT_W'(used);
  end

endmodule

// File: rtl/cq_store.sv
module cq_store
  import cmpl_queue_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DISP_N = 2,
  parameter int FIN_N  = 2,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [DISP_N-1:0]                wr_en_i,
  input  logic [DISP_N-1:0][PTR_W-1:0]     wr_slot_i,
  input  logic [DISP_N-1:0]                wr_done_i,
  input  logic [DISP_N-1:0][1:0]           wr_dst_i,
  input  logic [DISP_N-1:0][IDX_W-1:0]     wr_idx_i,
  input  logic [DISP_N-1:0][DATA_W-1:0]    wr_data_i,
  input  logic [FIN_N-1:0]                 fin_en_i,
  input  logic [FIN_N-1:0][PTR_W-1:0]      fin_slot_i,
  input  logic [FIN_N-1:0][DATA_W-1:0]     fin_data_i,
  input  logic [DEPTH-1:0]                 clr_i,
  output meta_t [DEPTH-1:0]                meta_o,
  output logic [DEPTH-1:0][DATA_W-1:0]     data_o
);

  meta_t [DEPTH-1:0]             meta_q;
  logic  [DEPTH-1:0][DATA_W-1:0] data_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[e] <= '0;
        data_q[e] <= '0;
      end else begin
        // later writes win: finish, then allocate, then clear
        for (int f = 0; f < FIN_N; f++) begin
          if (fin_en_i[f] && fin_slot_i[f] == PTR_W'(e) && meta_q[e].valid) begin
            meta_q[e].done <= 1'b1;
            data_q[e]      <= fin_data_i[f];
          end
        end
        for (int l = 0; l < DISP_N; l++) begin
          if (wr_en_i[l] && wr_slot_i[l] == PTR_W'(e)) begin
            meta_q[e].valid <= 1'b1;
            meta_q[e].done  <= wr_done_i[l];
            meta_q[e].dst   <= dst_e'(wr_dst_i[l]);
            meta_q[e].idx   <= wr_idx_i[l];
            data_q[e]       <= wr_data_i[l];
          end
        end
        if (clr_i[e]) begin
          meta_q[e].valid <= 1'b0;
          meta_q[e].done  <= 1'b0;
        end
      end
    end
  end

  assign meta_o = meta_q;
  assign data_o = data_q;

endmodule

// File: rtl/cq_retire.sv
module cq_retire
  import cmpl_queue_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int RET_N  = 2,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 3
) (
  input  meta_t [DEPTH-1:0]              meta_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]   data_i,
  input  logic [PTR_W-1:0]               head_i,
  input  logic                           flush_i,
  output logic [RET_N-1:0]               valid_o,
  output logic [RET_N-1:0][1:0]          dst_o,
  output logic [RET_N-1:0][IDX_W-1:0]    idx_o,
  output logic [RET_N-1:0][DATA_W-1:0]   data_o,
  output logic [DEPTH-1:0]               clr_o,
  output logic [CNT_W-1:0]               n_ret_o
);

  always_comb begin
    logic             stop;
    logic [PTR_W-1:0] s;
    int               n;
    stop  = flush_i;
    n     = 0;
    clr_o = '0;
    for (int r = 0; r < RET_N; r++) begin
      s          = PTR_W'(ring_add(int'(head_i), r, DEPTH));
      valid_o[r] = 1'b0;
      dst_o[r]   = meta_i[s].dst;
      idx_o[r]   = meta_i[s].idx;
      data_o[r]  = data_i[s];
      if (!stop && meta_i[s].valid && meta_i[s].done) begin
        valid_o[r] = 1'b1;
        clr_o[s]   = 1'b1;
        n          = n + 1;
      end else begin
        stop = 1'b1;  // strict program order
      end
    end
    n_ret_o = CNT_W'(n);
  end

endmodule

// File: rtl/cmpl_queue.sv
module cmpl_queue
  import cmpl_queue_pkg::*;
#(
  parameter  int DEPTH  = 6,
  parameter  int DISP_N = 2,
  parameter  int RET_N  = 2,
  parameter  int FIN_N  = 2,
  parameter  int DATA_W = 32,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DISP_N-1:0]             disp_valid_i,
  input  logic [DISP_N-1:0][1:0]        disp_kind_i,
  input  logic [DISP_N-1:0][1:0]        disp_dst_i,
  input  logic [DISP_N-1:0][IDX_W-1:0]  disp_idx_i,
  input  logic [DISP_N-1:0][DATA_W-1:0] disp_value_i,
  output logic [DISP_N-1:0]             disp_ack_o,
  output logic [DISP_N-1:0][PTR_W-1:0]  disp_tag_o,
  output logic [DISP_N-1:0]             issue_o,
  input  logic [FIN_N-1:0]              fin_valid_i,
  input  logic [FIN_N-1:0][PTR_W-1:0]   fin_tag_i,
  input  logic [FIN_N-1:0][DATA_W-1:0]  fin_data_i,
  input  logic                          flush_i,
  input  logic [PTR_W-1:0]              flush_tag_i,
  output logic [RET_N-1:0]              commit_valid_o,
  output logic [RET_N-1:0][1:0]         commit_dst_o,
  output logic [RET_N-1:0][IDX_W-1:0]   commit_idx_o,
  output logic [RET_N-1:0][DATA_W-1:0]  commit_data_o,
  output logic                          full_o,
  output logic                          empty_o,
  output logic [CNT_W-1:0]              count_o
);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  logic [DISP_N-1:0] take;
  logic [DISP_N-1:0] wr_done;
  logic [CNT_W-1:0]  n_take, n_ret;
  logic [DEPTH-1:0]  ret_clr, kill;

  meta_t [DEPTH-1:0]             meta;
  logic  [DEPTH-1:0][DATA_W-1:0] data;

  logic             flush_hit;
  logic [CNT_W-1:0] keep_cnt;

  cq_alloc #(
    .DEPTH(DEPTH), .DISP_N(DISP_N), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_alloc (
    .valid_i  (disp_valid_i),
    .kind_i   (disp_kind_i),
    .flush_i  (flush_i),
    .count_i  (count_q),
    .tail_i   (tail_q),
    .ack_o    (disp_ack_o),
    .take_o   (take),
    .issue_o  (issue_o),
    .slot_o   (disp_tag_o),
    .n_take_o (n_take)
  );

  for (genvar l = 0; l < DISP_N; l++) begin : g_wr_done
    assign wr_done[l] = (kind_e'(disp_kind_i[l]) == KIND_BR_REG);
  end

  cq_store #(
    .DEPTH(DEPTH), .DISP_N(DISP_N), .FIN_N(FIN_N), .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (take),
    .wr_slot_i  (disp_tag_o),
    .wr_done_i  (wr_done),
    .wr_dst_i   (disp_dst_i),
    .wr_idx_i   (disp_idx_i),
    .wr_data_i  (disp_value_i),
    .fin_en_i   (fin_valid_i),
    .fin_slot_i (fin_tag_i),
    .fin_data_i (fin_data_i),
    .clr_i      (ret_clr | kill),
    .meta_o     (meta),
    .data_o     (data)
  );

  cq_retire #(
    .DEPTH(DEPTH), .RET_N(RET_N), .DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_retire (
    .meta_i  (meta),
    .data_i  (data),
    .head_i  (head_q),
    .flush_i (flush_i),
    .valid_o (commit_valid_o),
    .dst_o   (commit_dst_o),
    .idx_o   (commit_idx_o),
    .data_o  (commit_data_o),
    .clr_o   (ret_clr),
    .n_ret_o (n_ret)
  );

  // flush only acts on an occupied slot
  always_comb begin
    flush_hit = flush_i && (int'(flush_tag_i) < DEPTH) && meta[flush_tag_i].valid;
    keep_cnt  = CNT_W'(ring_dist(int'(head_q), int'(flush_tag_i), DEPTH));
    for (int e = 0; e < DEPTH; e++) begin
      kill[e] = flush_hit && (ring_dist(int'(head_q), e, DEPTH) >= int'(keep_cnt));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q <= PTR_W'(ring_add(int'(head_q), int'(n_ret), DEPTH));
      if (flush_hit) begin
        tail_q  <= flush_tag_i;
        count_q <= keep_cnt;
      end else begin
        tail_q  <= PTR_W'(ring_add(int'(tail_q), int'(n_take), DEPTH));
        count_q <= count_q + n_take - n_ret;
      end
    end
  end

  assign count_o = count_q;
  assign full_o  = (int'(count_q) == DEPTH);
  assign empty_o = (count_q == '0);

endmodule

// File: rtl/cmpl_queue_chk.sv
module cmpl_queue_chk
  import cmpl_queue_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DISP_N = 2,
  parameter int RET_N  = 2,
  parameter int CNT_W  = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [DISP_N-1:0]       disp_valid_i,
  input logic [DISP_N-1:0][1:0]  disp_kind_i,
  input logic [DISP_N-1:0]       disp_ack_o,
  input logic [DISP_N-1:0]       issue_o,
  input logic                    flush_i,
  input logic [RET_N-1:0]        commit_valid_o,
  input logic                    full_o,
  input logic                    empty_o,
  input logic [CNT_W-1:0]        count_o
);

  logic [DISP_N-1:0] slot_lane, branch_lane;
  int   n_acc, n_com;
  logic live_q;

  always_comb begin
    for (int l = 0; l < DISP_N; l++) begin
      slot_lane[l]   = disp_valid_i[l] && (kind_e'(disp_kind_i[l]) != KIND_BR_NOREG);
      branch_lane[l] = (kind_e'(disp_kind_i[l]) == KIND_BR_NOREG) ||
                       (kind_e'(disp_kind_i[l]) == KIND_BR_REG);
    end
    n_acc = $countones(disp_ack_o & slot_lane);
    n_com = $countones(commit_valid_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= DEPTH);

  assert_count_track_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(flush_i)) |->
      int'(count_o) == int'($past(count_o)) + $past(n_acc) - $past(n_com));

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> ((disp_ack_o & slot_lane) == '0));

  assert_commit_contig_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_o & (commit_valid_o + 1'b1)) == '0);

  assert_branch_no_issue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o & branch_lane) == '0);

  assert_flush_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (commit_valid_o == '0 && disp_ack_o == '0));

  assert_empty_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (commit_valid_o == '0 && !full_o));

endmodule

bind cmpl_queue cmpl_queue_chk #(
  .DEPTH(DEPTH), .DISP_N(DISP_N), .RET_N(RET_N), .CNT_W(CNT_W)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .disp_valid_i   (disp_valid_i),
  .disp_kind_i    (disp_kind_i),
  .disp_ack_o     (disp_ack_o),
  .issue_o        (issue_o),
  .flush_i        (flush_i),
  .commit_valid_o (commit_valid_o),
  .full_o         (full_o),
  .empty_o        (empty_o),
  .count_o        (count_o)
);

// File: tb/cmpl_queue_tb_top.sv
module cmpl_queue_tb_top;

  localparam int D  = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]         disp_valid;
  logic [1:0][1:0]    disp_kind, disp_dst;
  logic [1:0][4:0]    disp_idx;
  logic [1:0][DW-1:0] disp_value;
  logic [1:0]         disp_ack, issue;
  logic [1:0][2:0]    disp_tag;
  logic [1:0]         fin_valid;
  logic [1:0][2:0]    fin_tag;
  logic [1:0][DW-1:0] fin_data;
  logic               flush;
  logic [2:0]         flush_tag;
  logic [1:0]         cv;
  logic [1:0][1:0]    c_dst;
  logic [1:0][4:0]    c_idx;
  logic [1:0][DW-1:0] c_data;
  logic               full, empty;
  logic [2:0]         count;

  cmpl_queue dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_kind_i(disp_kind), .disp_dst_i(disp_dst),
    .disp_idx_i(disp_idx), .disp_value_i(disp_value),
    .disp_ack_o(disp_ack), .disp_tag_o(disp_tag), .issue_o(issue),
    .fin_valid_i(fin_valid), .fin_tag_i(fin_tag), .fin_data_i(fin_data),
    .flush_i(flush), .flush_tag_i(flush_tag),
    .commit_valid_o(cv), .commit_dst_o(c_dst), .commit_idx_o(c_idx), .commit_data_o(c_data),
    .full_o(full), .empty_o(empty), .count_o(count)
  );

  int n_chk = 0;
  int n_err = 0;

  // reference queue
  int          m_head = 0, m_tail = 0, m_cnt = 0;
  bit          m_valid[D], m_done[D];
  int          m_dst[D], m_idx[D];
  logic [31:0] m_data[D];
  bit          e_take[2], e_com[2];
  int          e_tag[2];
  int          e_used, e_nret;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = '0; disp_kind = '0; disp_dst = '0; disp_idx = '0; disp_value = '0;
    fin_valid = '0; fin_tag = '0; fin_data = '0; flush = 1'b0; flush_tag = '0;
  endtask

  task automatic disp(input int l, input int k, input int dst, input int idx, input logic [31:0] v);
    disp_valid[l] = 1'b1; disp_kind[l] = 2'(k); disp_dst[l] = 2'(dst);
    disp_idx[l] = 5'(idx); disp_value[l] = v;
  endtask

  task automatic finish(input int f, input int tag, input logic [31:0] v);
    fin_valid[f] = 1'b1; fin_tag[f] = 3'(tag); fin_data[f] = v;
  endtask

  task automatic eval();
    int free, used; bit blocked, stop;
    #1;
    free = D - m_cnt; used = 0; blocked = flush;
    for (int l = 0; l < 2; l++) begin
      bit a, is; int tg;
      a = 0; is = 0; tg = (m_tail + used) % D; e_take[l] = 0; e_tag[l] = tg;
      if (disp_valid[l] && !blocked) begin
        if (disp_kind[l] == 2'd1) a = 1;
        else if (used < free) begin
          a = 1; is = (disp_kind[l] != 2'd2); e_take[l] = 1; used++;
        end else blocked = 1;
      end
      chk("R2", $sformatf("ack lane%0d", l), disp_ack[l], a);
      chk("R6", $sformatf("issue lane%0d", l), issue[l], is);
      if (e_take[l]) chk("R1", $sformatf("tag lane%0d", l), disp_tag[l], tg);
    end
    e_used = used;
    stop = flush; e_nret = 0;
    for (int r = 0; r < 2; r++) begin
      int s;
      s = (m_head + r) % D; e_com[r] = 0;
      if (!stop && m_valid[s] && m_done[s]) begin e_com[r] = 1; e_nret++; end
      else stop = 1;
      chk("R7", $sformatf("commit lane%0d", r), cv[r], e_com[r]);
      if (e_com[r]) begin
        chk("R8", "commit class", c_dst[r], m_dst[s]);
        chk("R8", "commit index", c_idx[r], m_idx[s]);
        chk("R8", "commit data", c_data[r], m_data[s]);
      end
    end
    chk("R3", "count", count, m_cnt);
    chk("R3", "full", full, m_cnt == D);
    chk("R3", "empty", empty, m_cnt == 0);
  endtask

  task automatic advance();
    bit sv[D];
    @(posedge clk);
    for (int e = 0; e < D; e++) sv[e] = m_valid[e];
    for (int f = 0; f < 2; f++)
      if (fin_valid[f] && fin_tag[f] < D && sv[fin_tag[f]]) begin
        m_done[fin_tag[f]] = 1; m_data[fin_tag[f]] = fin_data[f];
      end
    for (int l = 0; l < 2; l++)
      if (e_take[l]) begin
        m_valid[e_tag[l]] = 1; m_done[e_tag[l]] = (disp_kind[l] == 2'd2);
        m_dst[e_tag[l]] = disp_dst[l]; m_idx[e_tag[l]] = disp_idx[l];
        m_data[e_tag[l]] = disp_value[l];
      end
    m_tail = (m_tail + e_used) % D;
    for (int r = 0; r < 2; r++)
      if (e_com[r]) begin m_valid[(m_head + r) % D] = 0; m_done[(m_head + r) % D] = 0; end
    m_head = (m_head + e_nret) % D;
    m_cnt = m_cnt + e_used - e_nret;
    if (flush && flush_tag < D && sv[flush_tag]) begin
      int keep;
      keep = (int'(flush_tag) - m_head + D) % D;
      for (int e = 0; e < D; e++)
        if ((e - m_head + D) % D >= keep) begin m_valid[e] = 0; m_done[e] = 0; end
      m_tail = flush_tag; m_cnt = keep;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de5));
    idle();
    repeat (3) @(negedge clk);
    chk("R11", "count in reset", count, 0);
    chk("R11", "commit in reset", cv, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    eval();
    chk("R11", "empty after reset", empty, 1);
    advance();

    // link-writing branch plus plain branch
    disp(0, 2, 2, 0, 32'hABCD); disp(1, 1, 0, 0, 0);
    eval();
    chk("R4", "plain branch acked", disp_ack[1], 1);
    advance();
    idle(); eval();
    chk("R4", "no slot for plain branch", count, 1);
    chk("R5", "branch commits at once", cv[0], 1);
    chk("R5", "branch class link", c_dst[0], 2);
    chk("R5", "branch value", c_data[0], 32'hABCD);
    advance();

    // fill slots 1..5,0
    for (int c = 0; c < 3; c++) begin
      idle(); disp(0, 0, 0, 2 * c + 1, 0); disp(1, 0, 1, 2 * c + 2, 0);
      eval(); advance();
    end
    idle(); disp(0, 1, 0, 0, 0); disp(1, 0, 0, 9, 0);
    eval();
    chk("R4", "plain branch accepted when full", disp_ack[0], 1);
    chk("R2", "op refused when full", disp_ack[1], 0);
    advance();

    // younger finishes first: head blocks
    idle(); finish(0, 2, 32'h22);
    eval(); advance();
    idle(); finish(0, 1, 32'h11);
    eval();
    chk("R7", "unfinished head blocks", cv, 2'b00);
    advance();
    idle(); disp(0, 0, 0, 7, 0); disp(1, 0, 0, 8, 0);
    eval();
    chk("R7", "two commits", cv, 2'b11);
    chk("R2", "retire does not free slot early", disp_ack, 2'b00);
    advance();

    // flush from slot 4: keeps slot 3 only
    idle(); flush = 1'b1; flush_tag = 3'd4;
    eval(); advance();
    idle(); disp(0, 0, 0, 3, 0);
    eval();
    chk("R9", "count after flush", count, 1);
    chk("R9", "tag reused", disp_tag[0], 4);
    advance();

    // ignored flush and ignored finish
    idle(); flush = 1'b1; flush_tag = 3'd7; finish(0, 5, 32'h55);
    eval(); advance();
    idle(); disp(0, 0, 0, 4, 0);
    eval();
    chk("R10", "invalid flush ignored", count, 2);
    advance();
    idle(); finish(0, 3, 32'h33); finish(1, 4, 32'h44);
    eval(); advance();
    idle(); eval();
    chk("R7", "drain two", cv, 2'b11);
    advance();
    idle(); eval();
    chk("R10", "stale finish ignored", cv, 2'b00);
    advance();

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      idle();
      for (int l = 0; l < 2; l++) begin
        int k;
        k = $urandom % 20;
        if (($urandom % 10) < 6)
          disp(l, (k < 14) ? 0 : ((k < 17) ? 1 : 2), $urandom % 4, $urandom % 32, $urandom);
      end
      for (int f = 0; f < 2; f++) begin
        int s;
        s = $urandom % D;
        if (($urandom % 2) == 1 && ((m_valid[s] && !m_done[s]) || ($urandom % 10) == 0) &&
            !(f == 1 && fin_valid[0] && fin_tag[0] == 3'(s)))
          finish(f, s, $urandom);
      end
      if (($urandom % 40) == 0) begin flush = 1'b1; flush_tag = 3'($urandom % 8); end
      eval(); advance();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule